// File: doc/BRIEF.md
# System-Management Trigger and Protected Memory Window Controller

This block sits on the chipset's legacy I/O space. Software reaches its configuration bytes through a two-port scheme. A write to the index port picks a register. A write to the data port then updates the picked register. A read of the data port returns the picked register's contents.

Firmware uses the block for two jobs:

- **Software trigger.** Firmware can request a system-management interrupt from software. A trigger register emits a single-cycle pulse on either the SMI line or the IRQ15 line. A status byte records that the trigger fired, and software clears it by writing ones.
- **Protected memory window.** The same configuration byte controls how the 128 KB window at A0000h–BFFFFh is decoded. For every memory address, together with a flag that says whether the processor is in system-management mode, the block reports two things: whether the access hits protected RAM, and the DRAM address that serves it.

Register map (indices in hex). Bit positions are fixed because the decoders depend on them:

- 54h: trigger register. Bit 0 is the trigger bit.
- 55h: trigger status, write-one-to-clear.
- 5Bh: configuration byte.
  - Bit 7: master enable.
  - Bit 6: selects the high base (60000h) for the SMM mapping.
  - Bit 5: selects SMI rather than IRQ15 as the trigger output.
  - Bit 4: enables the SMM-only mapping.
  - Bit 3: enables the shared mapping onto the window's own DRAM.
  - Bit 1: enables the normal-mode mapping onto 30000h.
- 64h: reads as FFh.

Top module: `smm_window_ctl`

## Requirements
- R1: A write with `ioSelData`=0 loads `ioWrData` into the index. A write with `ioSelData`=1 stores `ioWrData` into the indexed register, and `ioRdData` then shows that register's value.
- R2: `ioRdData` is FFh while the index is 64h or any value of 80h or above. Data writes at those indices above 7Fh are dropped.
- R3: A data write to 55h clears each status bit whose written bit is 1 and leaves bits written 0 unchanged.
- R4: A data write to 54h fires the trigger only when 5Bh bit 7 is 1, the stored bit 0 of 54h is 0 and the written bit 0 is 1. Rewriting a 1 over a 1, or writing with bit 7 clear, produces no pulse.
- R5: When fired, the block outputs a pulse on `smiPulse` if 5Bh bit 5 is 1, otherwise on `irqPulse`. The pulse is high for exactly the one cycle after the write edge, and the two lines are never high together.
- R6: Firing the trigger sets register 55h to 01h.
- R7: With 5Bh bits 7 and 4 set and `smmActive`=1, an address in A0000h–BFFFFh hits. Its remapped address is the window offset added to 60000h when bit 6 is 1, or to 30000h when bit 6 is 0.
- R8: With 5Bh bits 7 and 3 set, an address in the window hits in either mode with the address unchanged. In SMM, bit 4 takes priority over bit 3.
- R9: With 5Bh bits 7 and 1 set and `smmActive`=0, an address in the window hits and is remapped onto base 30000h. Bit 3 takes priority over bit 1, and bit 1 has no effect in SMM.
- R10: When 5Bh bit 7 is 0, or the address lies outside A0000h–BFFFFh, `winHit` is 0 and `winAddr` equals `memAddr`.
- R11: Reset clears every register, the status byte, the index and both pulse outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWr | input | 1 | Port write strobe |
| ioSelData | input | 1 | 0 selects the index port, 1 selects the data port |
| ioWrData | input | 8 | Write data |
| ioRdData | output | 8 | Data-port read value for the current index |
| memAddr | input | 20 | Memory address to decode |
| smmActive | input | 1 | Processor is in system-management mode |
| smiPulse | output | 1 | One-cycle SMI request |
| irqPulse | output | 1 | One-cycle IRQ15 request |
| winHit | output | 1 | Address is served by protected RAM |
| winAddr | output | 20 | DRAM address serving the access |

## Verification
Two pairs of functions can land in the same cycle, and the bench provokes both.

The first pair is a window lookup and a write to the configuration byte. The bench holds a window address steady while a 5Bh write is on the bus. It checks that the decode still reflects the old mapping before the edge and the new mapping after it.

The second pair is a trigger pulse and the next port write. The bench places an index write to 55h directly behind a firing 54h write, so the pulse is on the output while the index loads. It then checks that the queued pulse arrived with the right kind and that the following write-one-to-clear still leaves the status at zero.

// File: rtl/smm_ctl_pkg.sv
package smm_ctl_pkg;
  localparam int IDX_W     = 8;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 20;
  localparam int REG_DEPTH = 128;
  localparam int REG_AW    = $clog2(REG_DEPTH);

  localparam logic [IDX_W-1:0] IDX_TRIG = 8'h54;
  localparam logic [IDX_W-1:0] IDX_STAT = 8'h55;
  localparam logic [IDX_W-1:0] IDX_CFG  = 8'h5B;
  localparam logic [IDX_W-1:0] IDX_JUMP = 8'h64;

  localparam int CFG_EN       = 7;
  localparam int CFG_HIBASE   = 6;
  localparam int CFG_TO_SMI   = 5;
  localparam int CFG_SMM_MAP  = 4;
  localparam int CFG_SHARED   = 3;
  localparam int CFG_NORM_LOW = 1;

  localparam logic [ADDR_W-1:0] WIN_BASE  = 20'hA0000;
  localparam logic [ADDR_W-1:0] LOW_BASE  = 20'h30000;
  localparam logic [ADDR_W-1:0] HIGH_BASE = 20'h60000;
  localparam int WIN_OFS_W = 17;

  typedef struct packed {
    logic loadIndex;
    logic writeReg;
    logic clearStatus;
    logic fire;
    logic toSmi;
  } smmStrobes_t;
endpackage

// File: rtl/smm_ctl_ctrl.sv
module smm_ctl_ctrl
  import smm_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWr,
  input  logic              ioSelData,
  input  logic [DATA_W-1:0] ioWrData,
  input  logic [DATA_W-1:0] cfgReg,
  input  logic              trigBit,
  output logic [IDX_W-1:0]  idx,
  output smmStrobes_t       strobes
);
  logic inRange;
  assign inRange = (idx[IDX_W-1:REG_AW] == '0);

  always_ff @(posedge clk) begin
    if (!rstN) idx <= '0;
    else if (strobes.loadIndex) idx <= ioWrData;
  end

  always_comb begin
    strobes = '0;
    strobes.toSmi = cfgReg[CFG_TO_SMI];
    if (ioWr && !ioSelData) strobes.loadIndex = 1'b1;
    if (ioWr && ioSelData) begin
      if (idx == IDX_STAT) strobes.clearStatus = 1'b1;
      else if (inRange)    strobes.writeReg = 1'b1;
      if (idx == IDX_TRIG && cfgReg[CFG_EN] && !trigBit && ioWrData[0])
        strobes.fire = 1'b1;
    end
  end

  // R1
  index_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && !ioSelData) |=> idx == $past(ioWrData));

  // R4
  fire_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fire |-> (ioSelData && idx == IDX_TRIG));
endmodule

// File: rtl/smm_ctl_datapath.sv
module smm_ctl_datapath
  import smm_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  smmStrobes_t       strobes,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] ioWrData,
  output logic [DATA_W-1:0] ioRdData,
  output logic [DATA_W-1:0] cfgReg,
  output logic              trigBit,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              smmActive,
  output logic              smiPulse,
  output logic              irqPulse,
  output logic              winHit,
  output logic [ADDR_W-1:0] winAddr
);
  localparam logic [REG_AW-1:0] STAT_SLOT = IDX_STAT[REG_AW-1:0];
  localparam logic [REG_AW-1:0] CFG_SLOT  = IDX_CFG[REG_AW-1:0];
  localparam logic [REG_AW-1:0] TRIG_SLOT = IDX_TRIG[REG_AW-1:0];

  logic [DATA_W-1:0] regFile [REG_DEPTH];
  logic [REG_AW-1:0] regIdx;
  logic              inRange;
  logic [DATA_W-1:0] statReg;

  assign regIdx  = idx[REG_AW-1:0];
  assign inRange = (idx[IDX_W-1:REG_AW] == '0);
  assign cfgReg  = regFile[CFG_SLOT];
  assign trigBit = regFile[TRIG_SLOT][0];
  assign statReg = regFile[STAT_SLOT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_DEPTH; i++) regFile[i] <= '0;
      smiPulse <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      if (strobes.writeReg)    regFile[regIdx] <= ioWrData;
      if (strobes.clearStatus) regFile[STAT_SLOT] <= statReg & ~ioWrData;
      if (strobes.fire)        regFile[STAT_SLOT] <= 8'h01;
      smiPulse <= strobes.fire &&  strobes.toSmi;
      irqPulse <= strobes.fire && !strobes.toSmi;
    end
  end

  always_comb begin
    if (!inRange || idx == IDX_JUMP) ioRdData = '1;
    else                             ioRdData = regFile[regIdx];
  end

  logic              inWin;
  logic [ADDR_W-1:0] mapBase;
  assign inWin = cfgReg[CFG_EN] &&
                 (memAddr[ADDR_W-1:WIN_OFS_W] == WIN_BASE[ADDR_W-1:WIN_OFS_W]);

  always_comb begin
    winHit  = 1'b0;
    mapBase = WIN_BASE;
    if (inWin) begin
      if (smmActive) begin
        if (cfgReg[CFG_SMM_MAP]) begin
          winHit  = 1'b1;
          mapBase = cfgReg[CFG_HIBASE] ? HIGH_BASE : LOW_BASE;
        end else if (cfgReg[CFG_SHARED]) begin
          winHit = 1'b1;
        end
      end else begin
        if (cfgReg[CFG_SHARED]) begin
          winHit = 1'b1;
        end else if (cfgReg[CFG_NORM_LOW]) begin
          winHit  = 1'b1;
          mapBase = LOW_BASE;
        end
      end
    end
    winAddr = winHit ? (mapBase + {{(ADDR_W-WIN_OFS_W){1'b0}}, memAddr[WIN_OFS_W-1:0]})
                     : memAddr;
  end

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearStatus |=> statReg == ($past(statReg) & ~$past(ioWrData)));

  // R5
  smi_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    smiPulse |=> !smiPulse);

  // R5
  irq_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  // R6
  status_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (smiPulse || irqPulse) |-> statReg == 8'h01);

  // R4
  fire_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (smiPulse || irqPulse) |-> $past(cfgReg[CFG_EN]));

  // R10
  hit_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    winHit |-> (cfgReg[CFG_EN] && memAddr[ADDR_W-1:WIN_OFS_W] == 3'b101));
endmodule

// File: rtl/smm_window_ctl.sv
module smm_window_ctl
  import smm_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWr,
  input  logic              ioSelData,
  input  logic [DATA_W-1:0] ioWrData,
  output logic [DATA_W-1:0] ioRdData,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              smmActive,
  output logic              smiPulse,
  output logic              irqPulse,
  output logic              winHit,
  output logic [ADDR_W-1:0] winAddr
);
  smmStrobes_t       strobes;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] cfgReg;
  logic              trigBit;

  smm_ctl_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioSelData(ioSelData),
    .ioWrData(ioWrData), .cfgReg(cfgReg), .trigBit(trigBit),
    .idx(idx), .strobes(strobes)
  );

  smm_ctl_datapath uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .idx(idx),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .cfgReg(cfgReg),
    .trigBit(trigBit), .memAddr(memAddr), .smmActive(smmActive),
    .smiPulse(smiPulse), .irqPulse(irqPulse), .winHit(winHit),
    .winAddr(winAddr)
  );
endmodule

// File: tb/tb_smm_window_ctl.sv
module tb_smm_window_ctl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioWr = 1'b0;
  logic        ioSelData = 1'b0;
  logic [7:0]  ioWrData = '0;
  logic [7:0]  ioRdData;
  logic [19:0] memAddr = '0;
  logic        smmActive = 1'b0;
  logic        smiPulse, irqPulse, winHit;
  logic [19:0] winAddr;

  int checks = 0;
  int errors = 0;
  bit monOn = 1'b0;
  bit expQ[$];   // 1 = SMI expected, 0 = IRQ15 expected
  bit prevPulse = 1'b0;

  always #5 clk = ~clk;

  smm_window_ctl dut (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioSelData(ioSelData),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .memAddr(memAddr),
    .smmActive(smmActive), .smiPulse(smiPulse), .irqPulse(irqPulse),
    .winHit(winHit), .winAddr(winAddr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Writes start and end on a falling edge, so successive calls are back-to-back.
  task automatic wr(bit sel, logic [7:0] v);
    ioWr = 1'b1; ioSelData = sel; ioWrData = v;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic setReg(logic [7:0] i, logic [7:0] v);
    wr(1'b0, i);
    wr(1'b1, v);
  endtask

  task automatic readChk(string req, logic [7:0] i, logic [7:0] exp);
    wr(1'b0, i);
    check(req, ioRdData, exp);
  endtask

  task automatic expectPulse(bit isSmi);
    expQ.push_back(isSmi);
  endtask

  task automatic winChk(string req, logic [19:0] a, bit smm, bit hit, logic [19:0] ra);
    memAddr = a; smmActive = smm;
    #1;
    check({req, " hit"}, winHit, hit);
    check({req, " addr"}, winAddr, ra);
  endtask

  // Monitor: scoreboard for trigger pulses.
  always @(negedge clk) begin
    if (monOn && rstN) begin
      if (smiPulse && irqPulse) begin
        checks++; errors++;
        $display("FAIL R5: both pulses high actual 11 expected one");
      end
      if (smiPulse || irqPulse) begin
        checks++;
        if (prevPulse) begin
          errors++;
          $display("FAIL R5: pulse longer than one cycle actual 2 expected 1");
        end else if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R4: unexpected pulse actual smi=%0b irq=%0b expected none", smiPulse, irqPulse);
        end else begin
          bit e;
          e = expQ.pop_front();
          if (smiPulse !== e) begin
            errors++;
            $display("FAIL R5: pulse kind actual smi=%0b expected smi=%0b", smiPulse, e);
          end
        end
      end
      prevPulse = smiPulse || irqPulse;
    end
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 rd", ioRdData, 8'h00);
    check("R11 smi", smiPulse, 1'b0);
    check("R11 irq", irqPulse, 1'b0);
    rstN = 1'b1;
    monOn = 1'b1;
    @(negedge clk);
    readChk("R11 cfg", 8'h5B, 8'h00);

    // R1 index/data access
    setReg(8'h10, 8'h3C);
    check("R1 readback", ioRdData, 8'h3C);
    setReg(8'h20, 8'h5A);
    check("R1 second", ioRdData, 8'h5A);
    readChk("R1 reindex", 8'h10, 8'h3C);

    // R2 forced FF reads
    setReg(8'h64, 8'hAA);
    check("R2 idx64", ioRdData, 8'hFF);
    setReg(8'h90, 8'h12);
    check("R2 idx90", ioRdData, 8'hFF);
    readChk("R2 low alias untouched", 8'h10, 8'h3C);

    // R4/R5/R6 trigger to SMI
    setReg(8'h5B, 8'hA0);
    wr(1'b0, 8'h54);
    expectPulse(1'b1);
    wr(1'b1, 8'h01);
    @(negedge clk);
    readChk("R6 status", 8'h55, 8'h01);
    wr(1'b1, 8'h01);
    check("R3 clear", ioRdData, 8'h00);

    // R4 1-over-1 does not fire
    setReg(8'h54, 8'h01);
    @(negedge clk);
    readChk("R4 no refire status", 8'h55, 8'h00);

    // R5 steered to IRQ15
    setReg(8'h54, 8'h00);
    setReg(8'h5B, 8'h80);
    wr(1'b0, 8'h54);
    expectPulse(1'b0);
    wr(1'b1, 8'h01);
    @(negedge clk);
    readChk("R6 status irq", 8'h55, 8'h01);
    wr(1'b1, 8'hFE);
    check("R3 zero bits keep", ioRdData, 8'h01);
    wr(1'b1, 8'hFF);
    check("R3 all clear", ioRdData, 8'h00);

    // R4 master enable clear blocks trigger
    setReg(8'h5B, 8'h20);
    setReg(8'h54, 8'h00);
    setReg(8'h54, 8'h01);
    @(negedge clk);
    readChk("R4 disabled status", 8'h55, 8'h00);

    // Pulse concurrent with index load, then W1C
    setReg(8'h5B, 8'hA0);
    setReg(8'h54, 8'h00);
    expectPulse(1'b1);
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h55);   // pulse is on the output during this write
    check("R6 back-to-back", ioRdData, 8'h01);
    wr(1'b1, 8'h01);
    check("R3 back-to-back", ioRdData, 8'h00);
    check("R5 queue drained", expQ.size(), 0);

    // Window decode
    setReg(8'h5B, 8'hD0);
    winChk("R7 smm high", 20'hA5432, 1'b1, 1'b1, 20'h65432);
    setReg(8'h5B, 8'h90);
    winChk("R7 smm low", 20'hA5432, 1'b1, 1'b1, 20'h35432);
    winChk("R7 normal miss", 20'hA5432, 1'b0, 1'b0, 20'hA5432);
    setReg(8'h5B, 8'h82);
    winChk("R9 normal low", 20'hBFFFF, 1'b0, 1'b1, 20'h4FFFF);
    winChk("R9 smm ignored", 20'hA5432, 1'b1, 1'b0, 20'hA5432);
    setReg(8'h5B, 8'h88);
    winChk("R8 normal", 20'hA5432, 1'b0, 1'b1, 20'hA5432);
    winChk("R8 smm", 20'hA0000, 1'b1, 1'b1, 20'hA0000);
    setReg(8'h5B, 8'h98);
    winChk("R8 smm priority", 20'hA5432, 1'b1, 1'b1, 20'h35432);
    setReg(8'h5B, 8'h8A);
    winChk("R9 shared priority", 20'hA5432, 1'b0, 1'b1, 20'hA5432);
    setReg(8'h5B, 8'h9A);
    winChk("R10 above", 20'hC0000, 1'b0, 1'b0, 20'hC0000);
    winChk("R10 below", 20'h9FFFF, 1'b1, 1'b0, 20'h9FFFF);

    // Config write while a lookup is held: old decode before edge, new after
    setReg(8'h5B, 8'h1A);
    winChk("R10 disabled", 20'hA5432, 1'b0, 1'b0, 20'hA5432);
    wr(1'b0, 8'h5B);
    ioWr = 1'b1; ioSelData = 1'b1; ioWrData = 8'h82;
    #1;
    check("R10 pre-edge hit", winHit, 1'b0);
    @(negedge clk);
    ioWr = 1'b0;
    check("R9 post-edge hit", winHit, 1'b1);
    check("R9 post-edge addr", winAddr, 20'h35432);

    repeat (3) @(negedge clk);
    check("R5 no missing pulse", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule